// File: doc/BRIEF.md
# Non-Shared Region Table

This block sits at a requesting node of a snoop-coherent system. It keeps a small set-associative record of memory regions that no other node is known to cache. A region is a naturally aligned block of memory of power-of-two size. It is named by its region number, which is the address shifted right by `REGION_LOG2` bits. Before the node sends a coherent request, it presents the address on the probe port. A hit, which is combinational, tells the node that the broadcast snoop may be skipped.

An entry is recorded when the combined response to one of the node's own requests shows that no remote node holds any block of that region. The record is self-correcting. Every snoop that arrives from another node removes any entry for the snooped region. When a set is full, it replaces the entry that was least recently allocated or refreshed.

The storage valid bits have no reset. A small controller therefore sweeps the sets after reset, one per cycle, before the table goes live. The controller has two states. `SWEEP` is entered on reset and clears one set per cycle. The transition `sweep_done` fires when the last set is cleared and leads to `READY`. `READY` holds until the next reset.

Top module: `region_filter_table`

## Requirements
- R1: After reset is released, `table_ready` stays low for exactly `SETS` (16) clock cycles and then stays high until the next reset. While it is low, `probe_hit` is 0 and allocations and snoops have no effect.
- R2: The region number is `addr >> REGION_LOG2` (14). Addresses that differ only in bits [13:0] name the same entry. Bits [17:14] select the set, and bits [31:18] form the stored tag.
- R3: When an allocation is presented for one cycle while the table is ready, a probe of that region hits from the following cycle. The hit is combinational on `probe_addr`.
- R4: A probe of a region that was never recorded misses. This includes a region in the same set with a different tag, and the same tag in a neighbouring set.
- R5: A snoop to a recorded region invalidates that entry from the next cycle. A snoop to another region of the same set leaves the entry intact.
- R6: If an allocation and a snoop for the same region arrive in the same cycle, no entry is recorded. If they name different regions, both take effect.
- R7: Allocating a region that is already present refreshes its recency and does not occupy a second way.
- R8: When an allocation finds its set full of valid entries, it replaces the entry that was least recently allocated or refreshed. Probes do not change recency.
- R9: An allocation fills an invalid way, taking the lowest-numbered one, before it evicts any valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_addr | input | ADDR_W (32) | Address of the request about to be issued |
| probe_hit | output | 1 | Region is recorded as non-shared (combinational) |
| alloc_valid | input | 1 | Combined response reported a global region miss |
| alloc_addr | input | ADDR_W (32) | Address of the request that received the global miss |
| snoop_valid | input | 1 | Snoop from another node is present |
| snoop_addr | input | ADDR_W (32) | Address of the foreign snoop |
| table_ready | output | 1 | Post-reset sweep has finished |

## Verification
The hardest cases to reach from the ports depend on replacement state inside a full set. These are the choice between a freed way and the recency victim, and the absence of a duplicate way on refresh. The stimulus fills a single set through several allocations whose ages it tracks by hand. It punches a hole with a snoop, or refreshes one tag several times, before adding one more region. Only the probe pattern across all the tags then shows which way was replaced.

// File: rtl/rft_pkg.sv
package rft_pkg;
    typedef enum logic [0:0] {
        SWEEP = 1'b0,
        READY = 1'b1
    } rft_state_t;
endpackage

// File: rtl/rft_age.sv
module rft_age #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] lru_way
);
    logic [WAY_W-1:0] age_q [WAYS];
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (clear) begin
                age_q[w] <= WAY_W'(w);
            end else if (touch) begin
                if (WAY_W'(w) == touch_way)
                    age_q[w] <= '0;
                else if (age_q[w] < age_q[touch_way])
                    age_q[w] <= age_q[w] + 1'b1;
            end
        end
    end

    always_comb begin
        lru_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (age_q[w] == OLDEST) lru_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/rft_set.sv
module rft_set #(
    parameter int TAG_W = 14,
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             clear,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             probe_match,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             inv_en,
    input  logic [TAG_W-1:0] inv_tag
);
    logic [TAG_W-1:0] tag_q [WAYS];
    logic [WAYS-1:0]  vld_q;

    logic [WAYS-1:0]  probe_vec, alloc_vec, inv_vec;
    logic [WAY_W-1:0] present_way, free_way, lru_way, target_way;
    logic             present, any_free;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign probe_vec[w] = vld_q[w] && (tag_q[w] == probe_tag);
            assign alloc_vec[w] = vld_q[w] && (tag_q[w] == alloc_tag);
            assign inv_vec[w]   = vld_q[w] && (tag_q[w] == inv_tag);
        end
    endgenerate

    assign probe_match = |probe_vec;
    assign present     = |alloc_vec;
    assign any_free    = ~&vld_q;

    always_comb begin
        present_way = '0;
        free_way    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (alloc_vec[w]) present_way = WAY_W'(w);
            if (!vld_q[w])    free_way    = WAY_W'(w);
        end
        if (present)       target_way = present_way;
        else if (any_free) target_way = free_way;
        else               target_way = lru_way;
    end

    rft_age #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
        .clk       (clk),
        .clear     (clear),
        .touch     (alloc_en),
        .touch_way (target_way),
        .lru_way   (lru_way)
    );

    always_ff @(posedge clk) begin
        if (clear) begin
            vld_q <= '0;
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (inv_en && inv_vec[w]) vld_q[w] <= 1'b0;
            end
            if (alloc_en && !present) begin
                tag_q[target_way] <= alloc_tag;
                vld_q[target_way] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rft_sweep.sv
module rft_sweep
    import rft_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clear_en,
    output logic [IDX_W-1:0] clear_idx,
    output logic             ready
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

    rft_state_t       state_q, state_d;
    logic [IDX_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SWEEP: if (cnt_q == LAST) state_d = READY;
            READY: state_d = READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SWEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SWEEP) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        clear_en  = 1'b0;
        ready     = 1'b0;
        clear_idx = cnt_q;
        unique case (state_q)
            SWEEP: clear_en = 1'b1;
            READY: ready    = 1'b1;
        endcase
    end
endmodule

// File: rtl/region_filter_table.sv
module region_filter_table #(
    parameter int ADDR_W      = 32,
    parameter int REGION_LOG2 = 14,
    parameter int SETS        = 16,
    parameter int WAYS        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              table_ready
);
    localparam int REG_W = ADDR_W - REGION_LOG2;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = REG_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    logic [REG_W-1:0] probe_reg, alloc_reg, snoop_reg;
    logic [IDX_W-1:0] probe_idx, alloc_idx, snoop_idx, clear_idx;
    logic [TAG_W-1:0] probe_tag, alloc_tag, snoop_tag;
    logic             clear_en, ready, collide;
    logic [SETS-1:0]  set_match;

    assign probe_reg = probe_addr[ADDR_W-1:REGION_LOG2];
    assign alloc_reg = alloc_addr[ADDR_W-1:REGION_LOG2];
    assign snoop_reg = snoop_addr[ADDR_W-1:REGION_LOG2];

    assign probe_idx = probe_reg[IDX_W-1:0];
    assign alloc_idx = alloc_reg[IDX_W-1:0];
    assign snoop_idx = snoop_reg[IDX_W-1:0];
    assign probe_tag = probe_reg[REG_W-1:IDX_W];
    assign alloc_tag = alloc_reg[REG_W-1:IDX_W];
    assign snoop_tag = snoop_reg[REG_W-1:IDX_W];

    assign collide = snoop_valid && (snoop_reg == alloc_reg);

    rft_sweep #(.SETS(SETS), .IDX_W(IDX_W)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_en  (clear_en),
        .clear_idx (clear_idx),
        .ready     (ready)
    );

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            logic sel_clear, sel_alloc, sel_inv;
            assign sel_clear = clear_en && (clear_idx == IDX_W'(s));
            assign sel_alloc = ready && alloc_valid && !collide
                               && (alloc_idx == IDX_W'(s));
            assign sel_inv   = ready && snoop_valid && (snoop_idx == IDX_W'(s));

            rft_set #(.TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_set (
                .clk         (clk),
                .clear       (sel_clear),
                .probe_tag   (probe_tag),
                .probe_match (set_match[s]),
                .alloc_en    (sel_alloc),
                .alloc_tag   (alloc_tag),
                .inv_en      (sel_inv),
                .inv_tag     (snoop_tag)
            );
        end
    endgenerate

    assign probe_hit   = ready && set_match[probe_idx];
    assign table_ready = ready;
endmodule

// File: rtl/rft_checker.sv
module rft_checker #(
    parameter int ADDR_W      = 32,
    parameter int REGION_LOG2 = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] probe_addr,
    input logic              probe_hit,
    input logic              alloc_valid,
    input logic [ADDR_W-1:0] alloc_addr,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              table_ready
);
    logic [ADDR_W-1:0] p_reg, a_reg, s_reg;
    assign p_reg = probe_addr >> REGION_LOG2;
    assign a_reg = alloc_addr >> REGION_LOG2;
    assign s_reg = snoop_addr >> REGION_LOG2;

    // R1
    quiet_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !table_ready |-> !probe_hit);

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        table_ready |=> table_ready);

    // R3
    alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(table_ready) && $past(alloc_valid)
         && !($past(snoop_valid) && ($past(s_reg) == $past(a_reg)))
         && (p_reg == $past(a_reg))) |-> probe_hit);

    // R5
    snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(table_ready) && $past(snoop_valid) && (p_reg == $past(s_reg)))
        |-> !probe_hit);
endmodule

bind region_filter_table rft_checker #(
    .ADDR_W      (ADDR_W),
    .REGION_LOG2 (REGION_LOG2)
) u_rft_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .probe_addr  (probe_addr),
    .probe_hit   (probe_hit),
    .alloc_valid (alloc_valid),
    .alloc_addr  (alloc_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .table_ready (table_ready)
);

// File: tb/region_filter_table_test.sv
module region_filter_table_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] probe_addr, alloc_addr, snoop_addr;
    logic        alloc_valid, snoop_valid;
    logic        probe_hit, table_ready;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    region_filter_table uut (
        .clk(clk), .rst_n(rst_n),
        .probe_addr(probe_addr), .probe_hit(probe_hit),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .table_ready(table_ready)
    );

    function automatic logic [31:0] mk(input int tg, input int st, input int off);
        logic [31:0] a;
        a = {tg[13:0], st[3:0], off[13:0]};
        return a;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bit(input string req, input string what,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic exp);
        probe_addr = a;
        #1;
        check_bit(req, $sformatf("probe %h", a), probe_hit, exp);
    endtask

    task automatic alloc(input logic [31:0] a);
        alloc_valid = 1'b1; alloc_addr = a;
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic snoop(input logic [31:0] a);
        snoop_valid = 1'b1; snoop_addr = a;
        tick();
        snoop_valid = 1'b0;
    endtask

    // R1: sweep length and silence
    task automatic t_reset();
        rst_n = 1'b0; alloc_valid = 0; snoop_valid = 0;
        probe_addr = '0; alloc_addr = '0; snoop_addr = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (15) tick();
        check_bit("R1", "table_ready after 15 cycles", table_ready, 1'b0);
        probe("R1", mk(0, 0, 0), 1'b0);
        tick();
        check_bit("R1", "table_ready after 16 cycles", table_ready, 1'b1);
        probe("R1", mk(0, 0, 0), 1'b0);
    endtask

    // R2, R3, R4: basic record and lookup
    task automatic t_basic();
        alloc(mk(5, 1, 16'h1234));
        probe("R3", mk(5, 1, 16'h1234), 1'b1);
        probe("R2", mk(5, 1, 16'h3FFF), 1'b1);
        probe("R2", mk(5, 1, 0), 1'b1);
        probe("R4", mk(5, 2, 0), 1'b0);
        probe("R4", mk(6, 1, 0), 1'b0);
        probe("R4", mk(100, 8, 7), 1'b0);
    endtask

    // R5: foreign snoops
    task automatic t_snoop();
        alloc(mk(9, 9, 0));
        snoop(mk(10, 9, 0));
        probe("R5", mk(9, 9, 0), 1'b1);
        snoop(mk(9, 9, 16'h2000));
        probe("R5", mk(9, 9, 0), 1'b0);
    endtask

    // R6: same-cycle collision
    task automatic t_collide();
        alloc_valid = 1'b1; alloc_addr = mk(3, 11, 0);
        snoop_valid = 1'b1; snoop_addr = mk(3, 11, 16'h0040);
        tick();
        alloc_valid = 1'b0; snoop_valid = 1'b0;
        probe("R6", mk(3, 11, 0), 1'b0);
        alloc(mk(4, 12, 0));
        alloc_valid = 1'b1; alloc_addr = mk(5, 12, 0);
        snoop_valid = 1'b1; snoop_addr = mk(4, 12, 0);
        tick();
        alloc_valid = 1'b0; snoop_valid = 1'b0;
        probe("R6", mk(5, 12, 0), 1'b1);
        probe("R6", mk(4, 12, 0), 1'b0);
    endtask

    // R7: refresh does not take a second way
    task automatic t_refresh();
        alloc(mk(1, 7, 0)); alloc(mk(2, 7, 0));
        alloc(mk(1, 7, 0)); alloc(mk(1, 7, 0)); alloc(mk(1, 7, 0));
        alloc(mk(3, 7, 0)); alloc(mk(4, 7, 0));
        for (int t = 1; t <= 4; t++) probe("R7", mk(t, 7, 0), 1'b1);
    endtask

    // R8: replacement order
    task automatic t_lru();
        for (int t = 1; t <= 4; t++) alloc(mk(t, 3, 0));
        alloc(mk(1, 3, 0));
        probe("R8", mk(2, 3, 0), 1'b1);
        alloc(mk(5, 3, 0));
        probe("R8", mk(2, 3, 0), 1'b0);
        probe("R8", mk(1, 3, 0), 1'b1);
        probe("R8", mk(3, 3, 0), 1'b1);
        probe("R8", mk(4, 3, 0), 1'b1);
        probe("R8", mk(5, 3, 0), 1'b1);
    endtask

    // R9: holes are filled first
    task automatic t_hole();
        for (int t = 1; t <= 4; t++) alloc(mk(t, 5, 0));
        snoop(mk(2, 5, 0));
        alloc(mk(6, 5, 0));
        probe("R9", mk(1, 5, 0), 1'b1);
        probe("R9", mk(3, 5, 0), 1'b1);
        probe("R9", mk(4, 5, 0), 1'b1);
        probe("R9", mk(6, 5, 0), 1'b1);
        probe("R9", mk(2, 5, 0), 1'b0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_snoop();
        t_collide();
        t_refresh();
        t_lru();
        t_hole();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule